// File: doc/BRIEF.md
# Serial Configuration Write Receiver

This block is a write-only slave on a two-wire serial bus (SMBus-style signalling). It watches a clock line and a data line that have already been brought into the system clock domain. It recognises start and stop conditions and checks the first byte against a fixed device address. After that it counts a fixed frame of eleven bytes. Only two of the eight data bytes carry live fields. These are the control byte (data byte 4) and the width/enable byte (data byte 5). They are held in a staging area and copied into the live configuration in one step, once the last data byte has been acknowledged.

The live configuration drives a set of clock-generator controls: input range, output range, modulation width, spread enable, PLL stop, and the enables for two clock outputs. One bit in the control byte picks where the range, width and spread controls come from. With the bit at 0 they follow dedicated pins, and with the bit at 1 they follow the register fields. Both clock outputs are gated: when an output is disabled it is driven low, never left floating. Power-up defaults make every serial write optional.

The serial side has no back-pressure. The slave never stretches the clock and never holds up the master. Each byte is taken at the speed the master sends it, and the only thing the slave sends back is the acknowledge bit.

Top module: `smcfg_top`

## Requirements
- R1: Only an address byte equal to 8'hD2 (write bit included) is acknowledged: `sda_drive_o` is 1 throughout the ninth clock of that byte. Any other address gets no acknowledge, and the rest of that frame is ignored with no register change.
- R2: After a matching address, each of the following ten bytes is acknowledged. Once the eleventh byte of the frame has been acknowledged, further bytes are not acknowledged until a new start condition.
- R3: Bits are taken most significant bit first, on rising edges of `scl_i`.
- R4: Bytes 2 and 3 of a frame (command and count) are counted but their values are ignored. Bytes 4 to 11 are data bytes 0 to 7. Data byte 4 is the control byte and data byte 5 is the width/enable byte; the other data bytes are discarded.
- R5: The live configuration changes only when all eight data bytes of a matched frame have been acknowledged. If the frame ends early (a stop or a start before that point), the configuration is left unchanged.
- R6: After reset the control byte is 8'h00 and the width/enable byte is 8'h30. So the controls follow the pins, the PLL runs, and both clock outputs are enabled.
- R7: Control byte layout: bit 2 selects the source, with 0 for pins and 1 for the registers. In register mode, `in_range_o` = control[6:5], `out_range_o` = control[4:3], `spread_en_o` = NOT control[0], and `width_o` = {wbyte[7], wbyte[6], wbyte[2]}. In pin mode these outputs equal `pin_in_range_i`, `pin_out_range_i`, `pin_width_i`, and NOT `pin_spread_n_i`.
- R8: `pll_stop_o` equals control bit 1 in both source modes.
- R9: `ref_clk_o` follows `ref_clk_i` when width/enable bit 5 is 1, and is held at 0 otherwise. `mod_clk_o` follows `mod_clk_i` when bit 4 is 1, and is held at 0 otherwise.
- R10: A stop condition returns the receiver to idle. A start condition at any point, including in mid-frame, begins a new frame at the address byte.
- R11: The slave drives the data line only during an acknowledge bit. `sda_drive_o` changes only while `scl_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, already synchronised |
| sda_i | input | 1 | Serial data line as seen on the wire, already synchronised |
| sda_drive_o | output | 1 | 1 pulls the data line low (acknowledge) |
| pin_in_range_i | input | 2 | Input range select from pins |
| pin_out_range_i | input | 2 | Output range select from pins |
| pin_width_i | input | 3 | Modulation width from pins, {high, mid, low} |
| pin_spread_n_i | input | 1 | Spread request from pin, active low |
| ref_clk_i | input | 1 | Unmodulated clock to be gated |
| mod_clk_i | input | 1 | Modulated clock to be gated |
| in_range_o | output | 2 | Effective input range select |
| out_range_o | output | 2 | Effective output range select |
| width_o | output | 3 | Effective modulation width |
| spread_en_o | output | 1 | Effective spread enable, active high |
| pll_stop_o | output | 1 | PLL stop request |
| ref_clk_o | output | 1 | Gated unmodulated clock, low when disabled |
| mod_clk_o | output | 1 | Gated modulated clock, low when disabled |

## Verification
Some rules are checked by the assertions on every cycle. The acknowledge drive moves only while the clock line is low. The live configuration never changes except in the cycle after a commit. A commit always comes right after an acknowledge, and a gated clock output rises only while its source is high. Other behaviour depends on the contents of a frame, and only the bench scenarios can show it. This covers address rejection, bytes past the frame end that get no acknowledge, truncated and restarted frames, ignored header values, and bit order. The bench also compares every effective control output against its own model on every clock, in both source modes.

// File: rtl/smcfg_pkg.sv
package smcfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_ACK   = 2'd2,
    RX_SKIP  = 2'd3
  } rx_state_t;

  typedef struct packed {
    logic [1:0] in_rng;
    logic [1:0] out_rng;
    logic [2:0] width;
    logic       spread_on;
  } ctl_t;
endpackage

// File: rtl/smcfg_bus_event.sv
module smcfg_bus_event (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // data edges while the clock line stays high mark bus conditions
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smcfg_frame_rx.sv
module smcfg_frame_rx
  import smcfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR    = 8'hD2,
  parameter int                FRAME_BYTES = 11,
  localparam int               IDX_W       = $clog2(FRAME_BYTES),
  localparam int               BIT_W       = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_drive_o,
  output logic              byte_vld_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic [BYTE_W-1:0] byte_dat_o,
  output logic              commit_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
  localparam logic [BIT_W-1:0] FULL_CNT = BIT_W'(BYTE_W);

  rx_state_t         state;
  logic [BIT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  byte_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              byte_done, addr_bad;

  assign byte_done = (state == RX_SHIFT) && scl_fall_i && (bit_cnt == FULL_CNT);
  assign addr_bad  = (byte_cnt == '0) && (shreg != DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= RX_IDLE;
      bit_cnt     <= '0;
      byte_cnt    <= '0;
      shreg       <= '0;
      sda_drive_o <= 1'b0;
      byte_vld_o  <= 1'b0;
      byte_idx_o  <= '0;
      byte_dat_o  <= '0;
      commit_o    <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      commit_o   <= 1'b0;
      if (start_i) begin
        state       <= RX_SHIFT;
        bit_cnt     <= '0;
        byte_cnt    <= '0;
        sda_drive_o <= 1'b0;
      end else if (stop_i) begin
        state       <= RX_IDLE;
        sda_drive_o <= 1'b0;
      end else begin
        unique case (state)
          RX_SHIFT: begin
            if (scl_rise_i && bit_cnt != FULL_CNT) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
              if (addr_bad) begin
                state <= RX_SKIP;
              end else begin
                state       <= RX_ACK;
                sda_drive_o <= 1'b1;
                byte_vld_o  <= 1'b1;
                byte_idx_o  <= byte_cnt;
                byte_dat_o  <= shreg;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall_i) begin
              sda_drive_o <= 1'b0;
              bit_cnt     <= '0;
              if (byte_cnt == LAST_IDX) begin
                state    <= RX_SKIP;
                commit_o <= 1'b1;
              end else begin
                state    <= RX_SHIFT;
                byte_cnt <= byte_cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smcfg_regfile.sv
module smcfg_regfile
  import smcfg_pkg::*;
#(
  parameter int                HDR_BYTES = 3,
  parameter int                CTL_IDX   = 4,
  parameter int                WID_IDX   = 5,
  parameter logic [BYTE_W-1:0] CTL_DEF   = 8'h00,
  parameter logic [BYTE_W-1:0] WID_DEF   = 8'h30,
  parameter int                IDX_W     = 4,
  localparam int               KEEP      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        byte_vld_i,
  input  logic [IDX_W-1:0]            byte_idx_i,
  input  logic [BYTE_W-1:0]           byte_dat_i,
  input  logic                        commit_i,
  output logic [KEEP-1:0][BYTE_W-1:0] live_o
);
  for (genvar g = 0; g < KEEP; g++) begin : g_keep
    localparam int                SLOT = HDR_BYTES + ((g == 0) ? CTL_IDX : WID_IDX);
    localparam logic [BYTE_W-1:0] DEFV = (g == 0) ? CTL_DEF : WID_DEF;
    logic [BYTE_W-1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage     <= DEFV;
        live_o[g] <= DEFV;
      end else begin
        if (byte_vld_i && (byte_idx_i == IDX_W'(SLOT))) stage <= byte_dat_i;
        if (commit_i) live_o[g] <= stage;
      end
    end
  end
endmodule

// File: rtl/smcfg_ctl_select.sv
module smcfg_ctl_select
  import smcfg_pkg::*;
(
  input  logic sw_sel_i,
  input  ctl_t sw_ctl_i,
  input  ctl_t pin_ctl_i,
  input  logic pll_stop_i,
  input  logic ref_en_i,
  input  logic mod_en_i,
  input  logic ref_clk_i,
  input  logic mod_clk_i,
  output ctl_t eff_ctl_o,
  output logic pll_stop_o,
  output logic ref_clk_o,
  output logic mod_clk_o
);
  always_comb begin
    eff_ctl_o  = sw_sel_i ? sw_ctl_i : pin_ctl_i;
    pll_stop_o = pll_stop_i;
    // a disabled output is driven low, never released
    ref_clk_o  = ref_clk_i & ref_en_i;
    mod_clk_o  = mod_clk_i & mod_en_i;
  end
endmodule

// File: rtl/smcfg_top.sv
module smcfg_top
  import smcfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR  = 8'hD2,
  parameter int                HDR_BYTES = 3,
  parameter int                NUM_DATA  = 8,
  parameter int                CTL_IDX   = 4,
  parameter int                WID_IDX   = 5,
  parameter logic [BYTE_W-1:0] CTL_DEF   = 8'h00,
  parameter logic [BYTE_W-1:0] WID_DEF   = 8'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_o,
  input  logic [1:0] pin_in_range_i,
  input  logic [1:0] pin_out_range_i,
  input  logic [2:0] pin_width_i,
  input  logic       pin_spread_n_i,
  input  logic       ref_clk_i,
  input  logic       mod_clk_i,
  output logic [1:0] in_range_o,
  output logic [1:0] out_range_o,
  output logic [2:0] width_o,
  output logic       spread_en_o,
  output logic       pll_stop_o,
  output logic       ref_clk_o,
  output logic       mod_clk_o
);
  localparam int FRAME_BYTES = HDR_BYTES + NUM_DATA;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  logic scl_rise, scl_fall, start_det, stop_det;
  logic byte_vld, commit;
  logic [IDX_W-1:0]       byte_idx;
  logic [BYTE_W-1:0]      byte_dat;
  logic [1:0][BYTE_W-1:0] cfg_live;
  ctl_t sw_ctl, pin_ctl, eff_ctl;

  smcfg_bus_event u_evt (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smcfg_frame_rx #(.DEV_ADDR(DEV_ADDR), .FRAME_BYTES(FRAME_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_drive_o(sda_drive_o), .byte_vld_o(byte_vld),
    .byte_idx_o(byte_idx), .byte_dat_o(byte_dat), .commit_o(commit)
  );

  smcfg_regfile #(
    .HDR_BYTES(HDR_BYTES), .CTL_IDX(CTL_IDX), .WID_IDX(WID_IDX),
    .CTL_DEF(CTL_DEF), .WID_DEF(WID_DEF), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld),
    .byte_idx_i(byte_idx), .byte_dat_i(byte_dat),
    .commit_i(commit), .live_o(cfg_live)
  );

  // field positions of the control and width/enable bytes
  assign sw_ctl.in_rng    = cfg_live[0][6:5];
  assign sw_ctl.out_rng   = cfg_live[0][4:3];
  assign sw_ctl.width     = {cfg_live[1][7], cfg_live[1][6], cfg_live[1][2]};
  assign sw_ctl.spread_on = ~cfg_live[0][0];

  assign pin_ctl.in_rng    = pin_in_range_i;
  assign pin_ctl.out_rng   = pin_out_range_i;
  assign pin_ctl.width     = pin_width_i;
  assign pin_ctl.spread_on = ~pin_spread_n_i;

  smcfg_ctl_select u_sel (
    .sw_sel_i(cfg_live[0][2]), .sw_ctl_i(sw_ctl), .pin_ctl_i(pin_ctl),
    .pll_stop_i(cfg_live[0][1]), .ref_en_i(cfg_live[1][5]),
    .mod_en_i(cfg_live[1][4]), .ref_clk_i(ref_clk_i), .mod_clk_i(mod_clk_i),
    .eff_ctl_o(eff_ctl), .pll_stop_o(pll_stop_o),
    .ref_clk_o(ref_clk_o), .mod_clk_o(mod_clk_o)
  );

  assign in_range_o  = eff_ctl.in_rng;
  assign out_range_o = eff_ctl.out_rng;
  assign width_o     = eff_ctl.width;
  assign spread_en_o = eff_ctl.spread_on;
endmodule

// File: rtl/smcfg_chk.sv
module smcfg_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_i,
  input logic            sda_drive_o,
  input logic            commit,
  input logic [1:0][7:0] cfg_live,
  input logic            mod_clk_i,
  input logic            mod_clk_o
);
  assert_drive_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_o) |-> !scl_i);

  assert_drive_fall_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_o) |-> !scl_i);

  assert_cfg_only_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(cfg_live));

  assert_commit_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(sda_drive_o));

  assert_gated_clk_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_clk_o) |-> mod_clk_i);
endmodule

bind smcfg_top smcfg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_drive_o(sda_drive_o),
  .commit(commit), .cfg_live(cfg_live),
  .mod_clk_i(mod_clk_i), .mod_clk_o(mod_clk_o)
);

// File: tb/smcfg_top_tb_top.sv
module smcfg_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_drive;
  logic [1:0] pin_in = 2'd0, pin_out = 2'd0;
  logic [2:0] pin_w = 3'd0;
  logic pin_sp_n = 1'b1;
  logic ref_ci = 1'b0, mod_ci = 1'b0;
  logic [1:0] in_r, out_r;
  logic [2:0] wid;
  logic sp_en, pll_stop, ref_co, mod_co;

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 0, finished = 0;
  logic [7:0] exp_ctl = 8'h00, exp_wid = 8'h30;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_drive;

  smcfg_top dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_o(sda_drive), .pin_in_range_i(pin_in), .pin_out_range_i(pin_out),
    .pin_width_i(pin_w), .pin_spread_n_i(pin_sp_n),
    .ref_clk_i(ref_ci), .mod_clk_i(mod_ci),
    .in_range_o(in_r), .out_range_o(out_r), .width_o(wid),
    .spread_en_o(sp_en), .pll_stop_o(pll_stop),
    .ref_clk_o(ref_co), .mod_clk_o(mod_co)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // gated clock sources toggle as plain data
  always @(negedge clk) begin
    ref_ci <= ~ref_ci;
    if (ref_ci) mod_ci <= ~mod_ci;
  end

  // behavioural model compared on every clock
  always @(posedge clk) begin
    #1;
    if (cmp_en) begin
      logic sw;
      logic [1:0] e_in, e_out;
      logic [2:0] e_w;
      logic e_sp;
      sw    = exp_ctl[2];
      e_in  = sw ? exp_ctl[6:5] : pin_in;
      e_out = sw ? exp_ctl[4:3] : pin_out;
      e_w   = sw ? {exp_wid[7], exp_wid[6], exp_wid[2]} : pin_w;
      e_sp  = sw ? ~exp_ctl[0] : ~pin_sp_n;
      check(in_r == e_in, "R7 in_range", in_r, e_in);
      check(out_r == e_out, "R7 out_range", out_r, e_out);
      check(wid == e_w, "R7 width", wid, e_w);
      check(sp_en == e_sp, "R7 spread", sp_en, e_sp);
      check(pll_stop == exp_ctl[1], "R8 pll_stop", pll_stop, exp_ctl[1]);
      check(ref_co == (ref_ci & exp_wid[5]), "R9 ref gate", ref_co, ref_ci & exp_wid[5]);
      check(mod_co == (mod_ci & exp_wid[4]), "R9 mod gate", mod_co, mod_ci & exp_wid[4]);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(3);
    scl = 1'b1; tick(4);
    sda_m = 1'b0; tick(5);
    scl = 1'b0; tick(3);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(3);
    scl = 1'b1; tick(5);
    sda_m = 1'b1; tick(5);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(3);
    scl = 1'b1; tick(3);
    check(sda_drive == 1'b0, "R11 no drive in data bit", sda_drive, 0);
    tick(3);
    scl = 1'b0; tick(3);
  endtask

  // R3: the byte goes out MSB first
  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req,
                           input bit last, input logic [7:0] nc, input logic [7:0] nw);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    sda_m = 1'b1; tick(3);
    scl = 1'b1; tick(3);
    check(sda_drive == exp_ack, req, sda_drive, exp_ack);
    tick(3);
    if (last) cmp_en = 0;
    scl = 1'b0; tick(3);
    if (last) begin
      exp_ctl = nc;
      exp_wid = nw;
      cmp_en  = 1;
    end
  endtask

  // full frame: address, command, count, n_data data bytes
  task automatic frame(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                       input logic [7:0] c4, input logic [7:0] w5, input int n_data,
                       input bit do_stop);
    logic m;
    m = (addr == 8'hD2);
    bus_start();
    send_byte(addr, m, "R1 address ack", 0, 0, 0);
    if (m) begin
      send_byte(cmd, 1'b1, "R4 command ack", 0, 0, 0);
      send_byte(cnt, 1'b1, "R4 count ack", 0, 0, 0);
      for (int k = 0; k < n_data; k++) begin
        logic [7:0] d;
        d = (k == 4) ? c4 : (k == 5) ? w5 : 8'hA5 ^ 8'(k);
        send_byte(d, 1'b1, "R2 data ack", (k == 7), c4, w5);
      end
    end else begin
      send_byte(8'h00, 1'b0, "R1 foreign frame ignored", 0, 0, 0);
      send_byte(c4, 1'b0, "R1 foreign frame ignored", 0, 0, 0);
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    cmp_en = 1;
    // R6 reset state
    check(pll_stop == 1'b0, "R6 pll runs", pll_stop, 0);
    check(sda_drive == 1'b0, "R6 idle no drive", sda_drive, 0);
    tick(2);
    check(mod_co == mod_ci, "R6 mod output enabled", mod_co, mod_ci);
    check(ref_co == ref_ci, "R6 ref output enabled", ref_co, ref_ci);
    // R7 pin mode follows pins
    pin_in = 2'd2; pin_out = 2'd1; pin_w = 3'b101; pin_sp_n = 1'b0; tick(3);
    check(wid == 3'b101 && sp_en, "R7 pin mode", {wid, sp_en}, 4'b1011);
    pin_in = 2'd1; pin_out = 2'd3; pin_w = 3'b010; pin_sp_n = 1'b1; tick(3);

    // R3 R4 R7: register mode, header values that resemble the address
    frame(8'hD2, 8'hD2, 8'hFF, 8'b0_10_01_1_0_1, 8'b1_0_1_1_0_1_0_0, 8, 1);
    check(in_r == 2'd2 && out_r == 2'd1, "R3 field order", {in_r, out_r}, 4'b1001);
    check(wid == 3'b101, "R7 register width", wid, 3'b101);
    pin_w = 3'b111; tick(3);
    check(wid == 3'b101, "R7 pins ignored in register mode", wid, 3'b101);

    // R1 foreign addresses: no ack, no change
    frame(8'hD3, 0, 0, 8'h00, 8'h00, 8, 1);
    frame(8'h52, 0, 0, 8'h00, 8'h00, 8, 1);
    check(wid == 3'b101 && !sp_en, "R1 no change", {wid, sp_en}, 4'b1010);

    // R5 truncated frame with stop
    frame(8'hD2, 8'h01, 8'h08, 8'h00, 8'h00, 6, 1);
    check(in_r == 2'd2, "R5 truncated unchanged", in_r, 2);

    // R10 repeated start mid frame, then a full frame commits
    frame(8'hD2, 8'h00, 8'h08, 8'h06, 8'h00, 5, 0);
    frame(8'hD2, 8'h00, 8'h08, 8'b0_11_00_1_1_0, 8'b0_1_0_1_0_1_0_0, 8, 0);
    check(pll_stop == 1'b1, "R10 restart commits", pll_stop, 1);
    check(wid == 3'b011 && sp_en, "R8 R7 fields", {wid, sp_en}, 4'b0111);
    // R2 byte after the frame end is not acked
    send_byte(8'h5A, 1'b0, "R2 past frame end", 0, 0, 0);
    bus_stop();
    tick(4);
    check(ref_co == 1'b0, "R9 ref held low", ref_co, 0);

    // back to pin mode, outputs re-enabled, pll stop kept in pin mode
    frame(8'hD2, 8'h00, 8'h00, 8'b0_00_00_0_1_0, 8'h30, 8, 1);
    pin_w = 3'b001; pin_sp_n = 1'b0; tick(4);
    check(pll_stop == 1'b1, "R8 stop in pin mode", pll_stop, 1);
    check(wid == 3'b001, "R7 pin mode again", wid, 1);
    frame(8'hD2, 8'h00, 8'h00, 8'h00, 8'h30, 8, 1);
    tick(10);
    check(sda_drive == 1'b0, "R10 idle after stop", sda_drive, 0);
    finish_run();
  end
endmodule